// File: doc/BRIEF.md
# Programmable External Chip-Select Generator

This block sits beside a microcontroller's external bus and turns each 16-bit bus address into up to four chip-select strobes: one for program memory, one general-purpose strobe, and two strobes for I/O expansion parts. External devices can then be wired straight to the bus with little or no glue logic. Software sets up the selects by writing eight small configuration registers. These registers hold the enables, the I/O polarity, the window bases and sizes, the priority order, the qualification timing and the per-select stretch counts.

On every bus cycle the block compares the address against two programmable power-of-two windows and two fixed I/O windows. The I/O windows follow a relocatable 4 KB register-block nibble. The block picks the single highest-priority hit and optionally waits for E-valid time before asserting that select. It also hands the bus sequencer the number of extra E-clock cycles the winning select needs. All outputs are registered on the E-clock-aligned `clk`, so they change on a clock edge only.

Top module: `chip_select_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all enables and fields are cleared. `prog_cs_n`, `io1_cs` and `io2_cs` read 1, `gen_cs` reads 0, and `stretch_count` reads 0. This holds for any address until software enables a select.
- R2: While `expanded_mode` is 0, every select is inactive and `stretch_count` is 0, whatever the configuration.
- R3: An address whose top nibble equals the register-block nibble (index 7, bits [3:0]) hits I/O 1 when its low 12 bits lie in 0x060..0x7FF and hits I/O 2 when they lie in 0x800..0xFFF. Low bits 0x000..0x05F hit neither I/O select.
- R4: Control register (index 0) bit 0 enables I/O 1 and bit 1 enables I/O 2. Bit 2 sets the I/O active level: 1 means active-high, 0 means active-low. The inactive level is the complement of the active level.
- R5: Control bit 3 enables the program select. Its window base is the upper address byte in index 1, and its size code in index 2 bits [2:0] gives a block of 256<<code bytes aligned to that size. `prog_cs_n` is active-low and is driven only while `addr_valid` is 1.
- R6: Control bit 4 enables the general-purpose select. Its base is in index 3 and its size code is in index 4 bits [2:0], with the same window rule as R5. `gen_cs` is active-high.
- R7: At most one select is active per cycle. I/O 1 and I/O 2 win over both windows. When the general and program windows both hit, the general select wins unless control bit 5 is 1, in which case the program select wins.
- R8: Timing register (index 5) bits 0, 1 and 2 make I/O 1, I/O 2 and the general select, respectively, also require `e_valid`. When the winning select needs `e_valid` and it is 0, no select is asserted.
- R9: `stretch_count` equals the winner's 2-bit field in index 6: bits [1:0] for program, [3:2] for general, [5:4] for I/O 1 and [7:6] for I/O 2. It is 0 when there is no winner or when `addr_valid` or `expanded_mode` is 0.
- R10: Outputs reflect the inputs sampled at the previous clock edge. A configuration write takes effect for the access sampled at the next edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock aligned to the external E clock |
| rst_n | input | 1 | Synchronous active-low reset |
| expanded_mode | input | 1 | 1 when the bus runs in an expanded mode |
| addr | input | 16 | Bus address |
| addr_valid | input | 1 | Address-valid phase of the bus cycle |
| e_valid | input | 1 | E-valid (data) phase of the bus cycle |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_data | input | 8 | Configuration write data |
| prog_cs_n | output | 1 | Program-memory select, active-low |
| gen_cs | output | 1 | General-purpose select, active-high |
| io1_cs | output | 1 | I/O select 1, programmable polarity |
| io2_cs | output | 1 | I/O select 2, programmable polarity |
| stretch_count | output | 2 | Extra E-clock cycles requested for this access |

## Verification
A wrong stored configuration bit or a bad window mask shows at the pins on the very next access that touches the affected window. The symptom is a select that fires on the wrong address, the wrong polarity, or a stretch count from the wrong field. A wrong priority shows as the wrong select, or as two selects together, for an address in the overlap of the two windows. Because every output is registered once, a reference model that tracks the written registers can predict each pin exactly one edge after the inputs and flag any divergence in that cycle.

// File: rtl/cs_pkg.sv
// Shared widths, register indices, configuration record and select codes
// for the chip-select generator. Assumes a 16-bit bus and byte-wide writes.
package cs_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BASE_W    = 8;   // window base is the upper address byte
    localparam int SIZE_W    = 3;   // block = 256 << code
    localparam int NIB_W     = 4;
    localparam int STR_W     = 2;
    localparam int IDX_W     = 3;
    localparam int WIN_CNT   = 2;   // programmable windows: general, program

    localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_PBASE   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_PSIZE   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_GBASE   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_GSIZE   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_TIMING  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_STRETCH = 3'd6;
    localparam logic [IDX_W-1:0] IDX_INIT    = 3'd7;

    typedef struct packed {
        logic              prog_first;
        logic              gen_en;
        logic              prog_en;
        logic              io_pol;
        logic              io2_en;
        logic              io1_en;
        logic [BASE_W-1:0] prog_base;
        logic [SIZE_W-1:0] prog_size;
        logic [BASE_W-1:0] gen_base;
        logic [SIZE_W-1:0] gen_size;
        logic              gen_eq;
        logic              io2_eq;
        logic              io1_eq;
        logic [STR_W-1:0]  st_io2;
        logic [STR_W-1:0]  st_io1;
        logic [STR_W-1:0]  st_gen;
        logic [STR_W-1:0]  st_prog;
        logic [NIB_W-1:0]  reg_nib;
    } cs_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_PROG = 3'd1,
        SEL_GEN  = 3'd2,
        SEL_IO1  = 3'd3,
        SEL_IO2  = 3'd4
    } cs_sel_e;
endpackage

// File: rtl/cs_regfile.sv
// Configuration store. Each indexed byte write updates only the fields
// that belong to that index; all fields clear on synchronous reset.
// Assumes writes are single-cycle strobes; there is no read-back path.
module cs_regfile
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output cs_cfg_t           cfg
);
    // Field update on an indexed write, full clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CTRL:    {cfg.prog_first, cfg.gen_en, cfg.prog_en,
                              cfg.io_pol, cfg.io2_en, cfg.io1_en} <= wr_data[5:0];
                IDX_PBASE:   cfg.prog_base <= wr_data[BASE_W-1:0];
                IDX_PSIZE:   cfg.prog_size <= wr_data[SIZE_W-1:0];
                IDX_GBASE:   cfg.gen_base  <= wr_data[BASE_W-1:0];
                IDX_GSIZE:   cfg.gen_size  <= wr_data[SIZE_W-1:0];
                IDX_TIMING:  {cfg.gen_eq, cfg.io2_eq, cfg.io1_eq} <= wr_data[2:0];
                IDX_STRETCH: {cfg.st_io2, cfg.st_io1, cfg.st_gen, cfg.st_prog} <= wr_data;
                IDX_INIT:    cfg.reg_nib <= wr_data[NIB_W-1:0];
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/cs_window_match.sv
// Power-of-two window compare: the page (upper address byte) matches when
// all bits above the size code agree with the base. Assumes code <= BASE_W-1.
module cs_window_match #(
    parameter int BASE_W = 8,
    parameter int SIZE_W = 3
) (
    input  logic [BASE_W-1:0] page,
    input  logic [BASE_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic              en,
    output logic              hit
);
    logic [BASE_W-1:0] keep_mask;

    // Masked compare of the page bits that lie above the block size.
    always_comb begin
        keep_mask = {BASE_W{1'b1}} << size;
        hit       = en && ((page & keep_mask) == (base & keep_mask));
    end
endmodule

// File: rtl/cs_io_match.sv
// Fixed I/O windows inside the relocatable register block: the top nibble
// selects the block, the low offset picks I/O 1 or I/O 2. Offsets below
// IO1_START belong to the on-chip registers and hit neither.
module cs_io_match #(
    parameter int ADDR_W = 16,
    parameter int NIB_W  = 4,
    parameter logic [ADDR_W-NIB_W-1:0] IO1_START = 'h060,
    parameter logic [ADDR_W-NIB_W-1:0] IO2_START = 'h800
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  nib,
    input  logic              io1_en,
    input  logic              io2_en,
    output logic              io1_hit,
    output logic              io2_hit
);
    localparam int OFF_W = ADDR_W - NIB_W;

    logic             in_block;
    logic [OFF_W-1:0] offset;

    // Block and offset range decode.
    always_comb begin
        in_block = addr[ADDR_W-1 -: NIB_W] == nib;
        offset   = addr[OFF_W-1:0];
        io1_hit  = io1_en && in_block && (offset >= IO1_START) && (offset < IO2_START);
        io2_hit  = io2_en && in_block && (offset >= IO2_START);
    end
endmodule

// File: rtl/cs_arbiter.sv
// Picks one winner from the hits, applies address-valid / E-valid
// qualification, and registers the pins and the stretch request.
// Assumes io1_hit and io2_hit are never both set.
module cs_arbiter
    import cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expanded_mode,
    input  logic             addr_valid,
    input  logic             e_valid,
    input  logic             prog_hit,
    input  logic             gen_hit,
    input  logic             io1_hit,
    input  logic             io2_hit,
    input  logic             prog_first,
    input  logic             io_pol,
    input  logic             gen_eq,
    input  logic             io1_eq,
    input  logic             io2_eq,
    input  logic [STR_W-1:0] st_prog,
    input  logic [STR_W-1:0] st_gen,
    input  logic [STR_W-1:0] st_io1,
    input  logic [STR_W-1:0] st_io2,
    output logic             prog_cs_n,
    output logic             gen_cs,
    output logic             io1_cs,
    output logic             io2_cs,
    output logic [STR_W-1:0] stretch_count
);
    cs_sel_e          winner;
    cs_sel_e          drive_sel;
    logic             need_e;
    logic [STR_W-1:0] win_stretch;

    // Fixed priority: I/O windows, then the swappable general/program pair.
    always_comb begin
        winner = SEL_NONE;
        if (expanded_mode && addr_valid) begin
            if (io1_hit)                   winner = SEL_IO1;
            else if (io2_hit)              winner = SEL_IO2;
            else if (gen_hit && prog_hit)  winner = prog_first ? SEL_PROG : SEL_GEN;
            else if (gen_hit)              winner = SEL_GEN;
            else if (prog_hit)             winner = SEL_PROG;
        end
    end

    // Qualification and stretch lookup for the winner.
    always_comb begin
        case (winner)
            SEL_IO1:  begin need_e = io1_eq; win_stretch = st_io1;  end
            SEL_IO2:  begin need_e = io2_eq; win_stretch = st_io2;  end
            SEL_GEN:  begin need_e = gen_eq; win_stretch = st_gen;  end
            SEL_PROG: begin need_e = 1'b0;   win_stretch = st_prog; end
            default:  begin need_e = 1'b0;   win_stretch = '0;      end
        endcase
        drive_sel = (need_e && !e_valid) ? SEL_NONE : winner;
    end

    // Pin registers, synchronous with the E-aligned clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_cs_n     <= 1'b1;
            gen_cs        <= 1'b0;
            io1_cs        <= 1'b1;
            io2_cs        <= 1'b1;
            stretch_count <= '0;
        end else begin
            prog_cs_n     <= drive_sel != SEL_PROG;
            gen_cs        <= drive_sel == SEL_GEN;
            io1_cs        <= (drive_sel == SEL_IO1) ? io_pol : !io_pol;
            io2_cs        <= (drive_sel == SEL_IO2) ? io_pol : !io_pol;
            stretch_count <= win_stretch;
        end
    end
endmodule

// File: rtl/chip_select_unit.sv
// Top of the chip-select generator: configuration store, two programmable
// windows (built by a generate loop), the fixed I/O decode and the arbiter.
// Assumes clk is aligned to the external E clock and inputs are synchronous.
module chip_select_unit
    import cs_pkg::*;
#(
    parameter logic [ADDR_W-NIB_W-1:0] IO1_START = 'h060,
    parameter logic [ADDR_W-NIB_W-1:0] IO2_START = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expanded_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  logic              e_valid,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              prog_cs_n,
    output logic              gen_cs,
    output logic              io1_cs,
    output logic              io2_cs,
    output logic [STR_W-1:0]  stretch_count
);
    localparam int WIN_GEN  = 0;
    localparam int WIN_PROG = 1;

    cs_cfg_t           cfg;
    logic [BASE_W-1:0] win_base [WIN_CNT];
    logic [SIZE_W-1:0] win_size [WIN_CNT];
    logic              win_en   [WIN_CNT];
    logic              win_hit  [WIN_CNT];
    logic              io1_hit;
    logic              io2_hit;

    cs_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .cfg     (cfg)
    );

    // Route each window's configuration into the per-window arrays.
    always_comb begin
        win_base[WIN_GEN]  = cfg.gen_base;
        win_size[WIN_GEN]  = cfg.gen_size;
        win_en[WIN_GEN]    = cfg.gen_en;
        win_base[WIN_PROG] = cfg.prog_base;
        win_size[WIN_PROG] = cfg.prog_size;
        win_en[WIN_PROG]   = cfg.prog_en;
    end

    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
        cs_window_match #(
            .BASE_W (BASE_W),
            .SIZE_W (SIZE_W)
        ) u_match (
            .page (addr[ADDR_W-1 -: BASE_W]),
            .base (win_base[w]),
            .size (win_size[w]),
            .en   (win_en[w]),
            .hit  (win_hit[w])
        );
    end

    cs_io_match #(
        .ADDR_W    (ADDR_W),
        .NIB_W     (NIB_W),
        .IO1_START (IO1_START),
        .IO2_START (IO2_START)
    ) u_io (
        .addr    (addr),
        .nib     (cfg.reg_nib),
        .io1_en  (cfg.io1_en),
        .io2_en  (cfg.io2_en),
        .io1_hit (io1_hit),
        .io2_hit (io2_hit)
    );

    cs_arbiter u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .expanded_mode (expanded_mode),
        .addr_valid    (addr_valid),
        .e_valid       (e_valid),
        .prog_hit      (win_hit[WIN_PROG]),
        .gen_hit       (win_hit[WIN_GEN]),
        .io1_hit       (io1_hit),
        .io2_hit       (io2_hit),
        .prog_first    (cfg.prog_first),
        .io_pol        (cfg.io_pol),
        .gen_eq        (cfg.gen_eq),
        .io1_eq        (cfg.io1_eq),
        .io2_eq        (cfg.io2_eq),
        .st_prog       (cfg.st_prog),
        .st_gen        (cfg.st_gen),
        .st_io1        (cfg.st_io1),
        .st_io2        (cfg.st_io2),
        .prog_cs_n     (prog_cs_n),
        .gen_cs        (gen_cs),
        .io1_cs        (io1_cs),
        .io2_cs        (io2_cs),
        .stretch_count (stretch_count)
    );
endmodule

// File: rtl/cs_checker.sv
// Property checker for chip_select_unit, attached by bind. It watches the
// pins plus the stored polarity, nibble and I/O 1 timing bit.
module cs_checker #(
    parameter int ADDR_W = 16,
    parameter int NIB_W  = 4,
    parameter logic [ADDR_W-NIB_W-1:0] IO1_START = 'h060,
    parameter logic [ADDR_W-NIB_W-1:0] IO2_START = 'h800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              expanded_mode,
    input logic              addr_valid,
    input logic              e_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_cs_n,
    input logic              gen_cs,
    input logic              io1_cs,
    input logic              io2_cs,
    input logic [1:0]        stretch_count,
    input logic              io_pol,
    input logic              io1_eq,
    input logic [NIB_W-1:0]  reg_nib
);
    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!prog_cs_n, gen_cs, io1_cs == $past(io_pol), io2_cs == $past(io_pol)})); // R7

    AST_SINGLE_CHIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !expanded_mode |=> (prog_cs_n && !gen_cs && io1_cs != $past(io_pol)
                            && io2_cs != $past(io_pol) && stretch_count == 2'd0)); // R2

    AST_IO1_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1 -: NIB_W] != reg_nib || addr[ADDR_W-NIB_W-1:0] < IO1_START
         || addr[ADDR_W-NIB_W-1:0] >= IO2_START) |=> io1_cs != $past(io_pol)); // R3

    AST_PROG_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (prog_cs_n && stretch_count == 2'd0)); // R5

    AST_IO1_WAITS_E: assert property (@(posedge clk) disable iff (!rst_n)
        (io1_eq && !e_valid) |=> io1_cs != $past(io_pol)); // R8
endmodule

bind chip_select_unit cs_checker #(
    .ADDR_W    (cs_pkg::ADDR_W),
    .NIB_W     (cs_pkg::NIB_W),
    .IO1_START (IO1_START),
    .IO2_START (IO2_START)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .expanded_mode (expanded_mode),
    .addr_valid    (addr_valid),
    .e_valid       (e_valid),
    .addr          (addr),
    .prog_cs_n     (prog_cs_n),
    .gen_cs        (gen_cs),
    .io1_cs        (io1_cs),
    .io2_cs        (io2_cs),
    .stretch_count (stretch_count),
    .io_pol        (cfg.io_pol),
    .io1_eq        (cfg.io1_eq),
    .reg_nib       (cfg.reg_nib)
);

// File: tb/chip_select_unit_test.sv
// Bench: a behavioural model keeps its own copy of the written bytes and
// predicts every pin one edge after the inputs; it is compared each cycle.
module chip_select_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        expanded_mode = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        addr_valid = 1'b0;
    logic        e_valid = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [7:0]  cfg_data = 8'h00;
    logic        prog_cs_n, gen_cs, io1_cs, io2_cs;
    logic [1:0]  stretch_count;

    int          total = 0;
    int          bad = 0;
    bit          chk_on = 1'b0;
    bit          done = 1'b0;
    string       cur_req = "R1";
    int          mreg [8];
    logic [5:0]  expv = 6'b101100;

    always #2 clk = ~clk;

    chip_select_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .expanded_mode (expanded_mode),
        .addr          (addr),
        .addr_valid    (addr_valid),
        .e_valid       (e_valid),
        .cfg_wr        (cfg_wr),
        .cfg_idx       (cfg_idx),
        .cfg_data      (cfg_data),
        .prog_cs_n     (prog_cs_n),
        .gen_cs        (gen_cs),
        .io1_cs        (io1_cs),
        .io2_cs        (io2_cs),
        .stretch_count (stretch_count)
    );

    function automatic bit in_window(int a, int base, int code);
        int blk = 256 << code;
        int lo  = ((base * 256) / blk) * blk;
        return (a >= lo) && (a < lo + blk);
    endfunction

    // Predicted {prog_cs_n, gen_cs, io1_cs, io2_cs, stretch[1:0]}.
    function automatic logic [5:0] predict(int a, bit em, bit av, bit ev);
        int ctrl = mreg[0];
        int off  = a % 4096;
        bit blk  = (a / 4096) == (mreg[7] % 16);
        bit h1   = ctrl[0] && blk && off >= 'h060 && off < 'h800;
        bit h2   = ctrl[1] && blk && off >= 'h800;
        bit hp   = ctrl[3] && in_window(a, mreg[1], mreg[2] % 8);
        bit hg   = ctrl[4] && in_window(a, mreg[3], mreg[4] % 8);
        bit pol  = ctrl[2];
        int win  = 0;
        int act;
        int st   = 0;
        bit need = 1'b0;
        if (em && av) begin
            if (h1)            win = 3;
            else if (h2)       win = 4;
            else if (hg && hp) win = ctrl[5] ? 1 : 2;
            else if (hg)       win = 2;
            else if (hp)       win = 1;
        end
        case (win)
            1: st = mreg[6] % 4;
            2: begin st = (mreg[6] / 4) % 4;  need = mreg[5][2]; end
            3: begin st = (mreg[6] / 16) % 4; need = mreg[5][0]; end
            4: begin st = (mreg[6] / 64) % 4; need = mreg[5][1]; end
            default: st = 0;
        endcase
        act = (need && !ev) ? 0 : win;
        return {act != 1, act == 2, (act == 3) ? pol : !pol,
                (act == 4) ? pol : !pol, 2'(st)};
    endfunction

    // Model update at each edge: predict from old registers, then apply write.
    always @(posedge clk) begin
        if (!rst_n) begin
            expv <= 6'b101100;
            for (int i = 0; i < 8; i++) mreg[i] = 0;
        end else begin
            expv <= predict(int'(addr), expanded_mode, addr_valid, e_valid);
            if (cfg_wr) mreg[cfg_idx] = int'(cfg_data);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [5:0] got;
            got = {prog_cs_n, gen_cs, io1_cs, io2_cs, stretch_count};
            total++;
            if (got !== expv) begin
                bad++;
                $display("FAIL %s at %0t: got=%b expected=%b", cur_req, $time, got, expv);
            end
        end
    end

    task automatic access(input logic [15:0] a, input bit av, input bit ev);
        @(negedge clk);
        cfg_wr = 1'b0; addr = a; addr_valid = av; e_valid = ev;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_data = d; addr_valid = 1'b0; e_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset values, then accesses with nothing enabled.
        cur_req = "R1";
        @(posedge clk);
        @(negedge clk) chk_on = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(16'h0060, 1, 1); access(16'hC000, 1, 1); access(16'h0900, 1, 0);

        // R3: I/O ranges around the register-block nibble 1, active-high.
        cur_req = "R3";
        wr(3'd0, 8'h07); wr(3'd7, 8'h01);
        access(16'h1000, 1, 1); access(16'h105F, 1, 1); access(16'h1060, 1, 1);
        access(16'h17FF, 1, 1); access(16'h1800, 1, 1); access(16'h1FFF, 1, 1);
        access(16'h2060, 1, 1); access(16'h0800, 1, 1);

        // R4: separate enables and active-low polarity.
        cur_req = "R4";
        wr(3'd0, 8'h01);
        access(16'h1100, 1, 1); access(16'h1900, 1, 1);
        wr(3'd0, 8'h06);
        access(16'h1100, 1, 1); access(16'h1900, 1, 1);

        // R5: program window C000..FFFF, address-valid only.
        cur_req = "R5";
        wr(3'd1, 8'hC0); wr(3'd2, 8'h06); wr(3'd0, 8'h08);
        access(16'hC000, 1, 0); access(16'hFFFF, 1, 1); access(16'hBFFF, 1, 1);
        access(16'hD234, 0, 1);

        // R6: general window E000..E7FF.
        cur_req = "R6";
        wr(3'd3, 8'hE0); wr(3'd4, 8'h03); wr(3'd0, 8'h10);
        access(16'hE000, 1, 1); access(16'hE7FF, 1, 1); access(16'hE800, 1, 1);
        access(16'hDFFF, 1, 1);

        // R7: priority with I/O block moved to E, then the swap bit.
        cur_req = "R7";
        wr(3'd0, 8'h1F); wr(3'd7, 8'h0E);
        access(16'hE100, 1, 1); access(16'hE040, 1, 1); access(16'hF000, 1, 1);
        wr(3'd0, 8'h3F);
        access(16'hE040, 1, 1); access(16'hE900, 1, 1); access(16'hE7F0, 1, 1);

        // R8: E-valid qualification of I/O 1, I/O 2 and general.
        cur_req = "R8";
        wr(3'd0, 8'h1F); wr(3'd5, 8'h07);
        access(16'hE100, 1, 0); access(16'hE100, 1, 1);
        access(16'hE040, 1, 0); access(16'hE040, 1, 1);
        access(16'hE900, 1, 0); access(16'hE900, 1, 1);
        access(16'hF000, 1, 0);

        // R9: stretch fields per winner, zero without a winner.
        cur_req = "R9";
        wr(3'd5, 8'h00); wr(3'd6, 8'h39);
        access(16'hF000, 1, 1); access(16'hE040, 1, 1); access(16'hE100, 1, 1);
        access(16'hE900, 1, 1); access(16'h4000, 1, 1); access(16'hF000, 0, 1);

        // R10: a write is visible to the very next access.
        cur_req = "R10";
        wr(3'd6, 8'hFF); access(16'hF000, 1, 1);
        wr(3'd0, 8'h00); access(16'hF000, 1, 1);
        wr(3'd0, 8'h1F); access(16'hE900, 1, 1);

        // R2: no select outside expanded mode.
        cur_req = "R2";
        expanded_mode = 1'b0;
        access(16'hE100, 1, 1); access(16'hF000, 1, 1); access(16'hE040, 1, 1);
        expanded_mode = 1'b1;
        access(16'hE100, 1, 1);

        // R9: mixed random traffic and configuration writes.
        cur_req = "R9";
        for (int n = 0; n < 800; n++) begin
            if ($urandom_range(0, 9) == 0)
                wr(3'($urandom_range(0, 7)), 8'($urandom));
            else begin
                expanded_mode = ($urandom_range(0, 15) != 0);
                access(16'($urandom), 1'($urandom_range(0, 5) != 0), 1'($urandom));
            end
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule